// File: doc/BRIEF.md
# Quadrature Encoder Clock Converter

This block converts the two-phase square waves of an incremental encoder into count strobes for an external up/down counter. The encoder lines `enc_a` and `enc_b` are asynchronous. Each one is brought into the clock domain by a two-flop chain. It then passes through its own validation filter, which accepts a new level only after the level has stayed unchanged for a programmable number of cycles. Each accepted change of the filtered pair is classified as a forward step, a reverse step or an illegal jump. A resolution setting then gates it, and a qualifying step fires an active-low pulse whose length is a loadable cycle count.

There are two output styles. In split style, forward steps pulse `up_n` and reverse steps pulse `dn_n`. In combined style, every step pulses `cnt_clk_n`, and `cnt_dir` carries the direction. `cnt_dir` changes at the same edge on which the pulse falls, so a counter that counts on the rising edge of `cnt_clk_n` always sees a settled direction.

While a pulse is being emitted, both validation filters are frozen, so encoder dither cannot produce extra counts. The outputs are plain strobes with no handshake. Nothing downstream can apply back-pressure, and a step is never queued: a level change that is still present when the pulse ends is validated afresh.

Top module: `quad_clk_conv`

## Requirements
- R1: While reset is held, and right after it is released, `up_n`, `dn_n` and `cnt_clk_n` are high, `cnt_dir` is high and `step_err` is low.
- R2: The filtered state is read as {A,B}. The sequence 00→10→11→01→00 is forward (A leads B) and the reverse sequence is backward. With `res_mode` = 2'b10 or 2'b11 (x4), every single-line change produces a pulse. In split style, forward steps pulse `up_n` low and backward steps pulse `dn_n` low, and the two are never low together.
- R3: With `res_mode` = 2'b01 (x2), only changes of A produce a pulse, with the direction taken from the sequence in R2. Changes of B alone produce none.
- R4: With `res_mode` = 2'b00 (x1), only a rising A produces a pulse: up when B is low, down when B is high. A falling A and any change of B produce none.
- R5: A pulse stays low for exactly `pulse_cycles` clock cycles. A value of 0 acts as 1.
- R6: With `combined` = 1 the step pulses `cnt_clk_n` low and `up_n`/`dn_n` stay high. With `combined` = 0 `cnt_clk_n` stays high. `cnt_dir` takes 1 for forward and 0 for backward at the edge on which the pulse starts, and it holds that value until the next pulse.
- R7: A new level on a line is accepted only if the synchronised line shows it for `val_cycles` consecutive samples. A shorter excursion produces nothing. A value of 0 acts as 1.
- R8: While a pulse is low, changes on A and B are ignored and the filter counts are cleared. A change that is still present when the pulse ends is validated from the beginning and then counted.
- R9: If both lines are accepted in the same cycle (an illegal jump), no pulse is produced and `step_err` is high for exactly one cycle.
- R10: A line change first captured at clock edge k starts its pulse (or its `step_err`) at edge k + `val_cycles` + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| res_mode | input | 2 | Resolution: 00 x1, 01 x2, 1x x4 |
| combined | input | 1 | 1 selects clock + direction outputs, 0 selects split strobes |
| val_cycles | input | VAL_W | Validation length in cycles |
| pulse_cycles | input | PW_W | Output pulse length in cycles |
| up_n | output | 1 | Active-low forward strobe (split style) |
| dn_n | output | 1 | Active-low backward strobe (split style) |
| cnt_clk_n | output | 1 | Active-low count strobe (combined style) |
| cnt_dir | output | 1 | Count direction, 1 = forward |
| step_err | output | 1 | One-cycle flag for an illegal jump |

## Verification
The bench drives the encoder lines half a cycle before edge k. It samples every output half a cycle after an edge, so the sample after edge k+j is taken j+1 falling edges after the drive. The first pulse sample is therefore taken `val_cycles`+3 falling edges after the drive, and one falling edge earlier all outputs must still be idle. The last low sample of a pulse falls `pulse_cycles`−1 falling edges after the first one, and the next sample must be high. Because `step_err` lasts one cycle, the bench checks it one falling edge after it appears. The filter and freeze tests count pulse falls over a long window and compare the count with the number of steps that the rules allow.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

  typedef enum logic [1:0] {
    RES_X1 = 2'b00,
    RES_X2 = 2'b01,
    RES_X4 = 2'b10
  } res_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_FWD  = 2'b01,
    STEP_REV  = 2'b10,
    STEP_BAD  = 2'b11
  } step_e;

  function automatic res_e decode_res(input logic [1:0] m);
    case (m)
      2'b00:   return RES_X1;
      2'b01:   return RES_X2;
      default: return RES_X4;
    endcase
  endfunction

  // state bits are {A,B}; forward cycle 00->10->11->01->00
  function automatic step_e classify(input logic [1:0] prv, input logic [1:0] cur);
    logic [1:0] fwd_next;
    case (prv)
      2'b00:   fwd_next = 2'b10;
      2'b10:   fwd_next = 2'b11;
      2'b11:   fwd_next = 2'b01;
      default: fwd_next = 2'b00;
    endcase
    if (cur == prv)            return STEP_NONE;
    if ((cur ^ prv) == 2'b11)  return STEP_BAD;
    if (cur == fwd_next)       return STEP_FWD;
    return STEP_REV;
  endfunction

endpackage

// File: rtl/qcc_sync.sv
module qcc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/qcc_filter.sv
module qcc_filter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          hold,
  input  logic [CW-1:0] val_cycles,
  output logic          level
);
  localparam int XW = CW + 1;

  logic [CW-1:0] run_q;
  logic [XW-1:0] limit;
  logic [XW-1:0] run_next;

  always_comb begin
    limit    = (val_cycles == '0) ? XW'(1) : {1'b0, val_cycles};
    run_next = {1'b0, run_q} + XW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      level <= 1'b0;
    end else if (hold || (din == level)) begin
      run_q <= '0;
    end else if (run_next >= limit) begin
      level <= din;
      run_q <= '0;
    end else begin
      run_q <= run_next[CW-1:0];
    end
  end
endmodule

// File: rtl/qcc_decode.sv
module qcc_decode
  import qcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cur,
  input  logic [1:0] res_mode,
  output logic       pend,
  output logic       fire,
  output logic       fire_up,
  output logic       err_q
);
  logic [1:0] prev_q;
  step_e      step;
  res_e       res;
  logic       gate_ok;

  always_comb begin
    step = classify(prev_q, cur);
    res  = decode_res(res_mode);
    case (res)
      RES_X1:  gate_ok = !prev_q[1] && cur[1];
      RES_X2:  gate_ok = prev_q[1] ^ cur[1];
      default: gate_ok = 1'b1;
    endcase
    pend    = (cur != prev_q);
    fire    = ((step == STEP_FWD) || (step == STEP_REV)) && gate_ok;
    fire_up = (step == STEP_FWD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      err_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      err_q  <= (step == STEP_BAD);
    end
  end
endmodule

// File: rtl/qcc_pulse.sv
module qcc_pulse #(
  parameter int PW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            fire_up,
  input  logic            combined,
  input  logic [PW_W-1:0] pulse_cycles,
  output logic            busy,
  output logic            up_n,
  output logic            dn_n,
  output logic            cnt_clk_n,
  output logic            cnt_dir
);
  logic [PW_W-1:0] left_q;
  logic            is_up_q;
  logic            comb_q;
  logic [PW_W-1:0] load_val;

  always_comb begin
    load_val = (pulse_cycles == '0) ? '0 : pulse_cycles - PW_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      left_q  <= '0;
      is_up_q <= 1'b1;
      comb_q  <= 1'b0;
      cnt_dir <= 1'b1;
    end else if (fire && !busy) begin
      busy    <= 1'b1;
      left_q  <= load_val;
      is_up_q <= fire_up;
      comb_q  <= combined;
      cnt_dir <= fire_up;
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - PW_W'(1);
    end
  end

  always_comb begin
    up_n      = !(busy && !comb_q && is_up_q);
    dn_n      = !(busy && !comb_q && !is_up_q);
    cnt_clk_n = !(busy && comb_q);
  end
endmodule

// File: rtl/quad_clk_conv.sv
module quad_clk_conv #(
  parameter int VAL_W = 8,
  parameter int PW_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic [1:0]       res_mode,
  input  logic             combined,
  input  logic [VAL_W-1:0] val_cycles,
  input  logic [PW_W-1:0]  pulse_cycles,
  output logic             up_n,
  output logic             dn_n,
  output logic             cnt_clk_n,
  output logic             cnt_dir,
  output logic             step_err
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_ab;
  logic [NLINES-1:0] sync_ab;
  logic [NLINES-1:0] filt_ab;
  logic              pend;
  logic              fire;
  logic              fire_up;
  logic              busy;
  logic              hold;

  assign raw_ab = {enc_a, enc_b};
  assign hold   = busy || pend;

  qcc_sync #(.W(NLINES), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_ab),
    .d_sync  (sync_ab)
  );

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      qcc_filter #(.CW(VAL_W)) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (sync_ab[i]),
        .hold       (hold),
        .val_cycles (val_cycles),
        .level      (filt_ab[i])
      );
    end
  endgenerate

  qcc_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (filt_ab),
    .res_mode (res_mode),
    .pend     (pend),
    .fire     (fire),
    .fire_up  (fire_up),
    .err_q    (step_err)
  );

  qcc_pulse #(.PW_W(PW_W)) u_pulse (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (fire),
    .fire_up      (fire_up),
    .combined     (combined),
    .pulse_cycles (pulse_cycles),
    .busy         (busy),
    .up_n         (up_n),
    .dn_n         (dn_n),
    .cnt_clk_n    (cnt_clk_n),
    .cnt_dir      (cnt_dir)
  );
endmodule

// File: rtl/qcc_checker.sv
module qcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       up_n,
  input logic       dn_n,
  input logic       cnt_clk_n,
  input logic       cnt_dir,
  input logic       step_err,
  input logic       busy,
  input logic [1:0] filt
);
  AST_SPLIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!up_n && !dn_n)); // R2
  AST_STYLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((!up_n || !dn_n) && !cnt_clk_n)); // R6
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clk_n && $past(!cnt_clk_n)) |-> $stable(cnt_dir)); // R6
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(filt)); // R8
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |=> !step_err); // R9
  AST_ERR_NOPULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |-> (up_n && dn_n && cnt_clk_n)); // R9
endmodule

bind quad_clk_conv qcc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_n      (up_n),
  .dn_n      (dn_n),
  .cnt_clk_n (cnt_clk_n),
  .cnt_dir   (cnt_dir),
  .step_err  (step_err),
  .busy      (busy),
  .filt      (filt_ab)
);

// File: tb/quad_clk_conv_test.sv
`timescale 1ns/1ps
module quad_clk_conv_test;
  localparam int VAL_W = 8;
  localparam int PW_W  = 16;
  localparam int V     = 3;
  localparam int PW    = 4;
  localparam int NROWS = 28;

  // row: mode[9:8] comb[7] a[6] b[5] up[4] dn[3] clk[2] dir[1] err[0]
  localparam logic [9:0] ROWS [NROWS] = '{
    10'b10_0_10_1_0_0_1_0, 10'b10_0_11_1_0_0_1_0, 10'b10_0_01_1_0_0_1_0, 10'b10_0_00_1_0_0_1_0,
    10'b10_0_01_0_1_0_0_0, 10'b10_0_11_0_1_0_0_0, 10'b10_0_10_0_1_0_0_0, 10'b10_0_00_0_1_0_0_0,
    10'b01_0_10_1_0_0_1_0, 10'b01_0_11_0_0_0_0_0, 10'b01_0_01_1_0_0_1_0, 10'b01_0_00_0_0_0_0_0,
    10'b01_0_01_0_0_0_0_0, 10'b01_0_11_0_1_0_0_0, 10'b01_0_10_0_0_0_0_0, 10'b01_0_00_0_1_0_0_0,
    10'b00_0_10_1_0_0_1_0, 10'b00_0_00_0_0_0_0_0, 10'b00_0_01_0_0_0_0_0, 10'b00_0_11_0_1_0_0_0,
    10'b00_0_10_0_0_0_0_0, 10'b00_0_00_0_0_0_0_0,
    10'b11_1_10_0_0_1_1_0, 10'b11_1_00_0_0_1_0_0, 10'b11_1_01_0_0_1_0_0, 10'b11_1_00_0_0_1_1_0,
    10'b10_0_11_0_0_0_0_1, 10'b10_0_00_0_0_0_0_1
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enc_a = 1'b0;
  logic             enc_b = 1'b0;
  logic [1:0]       res_mode = 2'b10;
  logic             combined = 1'b0;
  logic [VAL_W-1:0] val_cycles = VAL_W'(V);
  logic [PW_W-1:0]  pulse_cycles = PW_W'(PW);
  logic             up_n, dn_n, cnt_clk_n, cnt_dir, step_err;

  int  n_checks = 0;
  int  n_errors = 0;
  int  up_falls = 0, dn_falls = 0, ck_falls = 0, err_hits = 0;
  logic up_p = 1'b1, dn_p = 1'b1, ck_p = 1'b1;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  quad_clk_conv #(.VAL_W(VAL_W), .PW_W(PW_W)) uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .res_mode(res_mode), .combined(combined), .val_cycles(val_cycles),
    .pulse_cycles(pulse_cycles), .up_n(up_n), .dn_n(dn_n),
    .cnt_clk_n(cnt_clk_n), .cnt_dir(cnt_dir), .step_err(step_err)
  );

  always @(negedge clk) begin
    if (up_p && !up_n) up_falls++;
    if (dn_p && !dn_n) dn_falls++;
    if (ck_p && !cnt_clk_n) ck_falls++;
    if (step_err) err_hits++;
    up_p = up_n; dn_p = dn_n; ck_p = cnt_clk_n;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic eu, input logic ed,
                            input logic ec, input logic ee);
    logic [3:0] act, exp;
    act = {up_n, dn_n, cnt_clk_n, step_err};
    exp = {~eu, ~ed, ~ec, ee};
    check(act == exp, req, "{up_n,dn_n,cnt_clk_n,step_err}", int'(act), int'(exp));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_counts();
    up_falls = 0; dn_falls = 0; ck_falls = 0; err_hits = 0;
  endtask

  task automatic run_row(input logic [9:0] r, input int idx);
    string tag;
    case (r[9:8])
      2'b00:   tag = "R4";
      2'b01:   tag = "R3";
      default: tag = r[7] ? "R6" : (r[0] ? "R9" : "R2");
    endcase
    res_mode = r[9:8]; combined = r[7]; enc_a = r[6]; enc_b = r[5];
    ticks(V + 2);
    check_outs("R10", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(1);
    check_outs(tag, r[4], r[3], r[2], r[0]);
    if (r[2]) check(cnt_dir == r[1], "R6", $sformatf("row %0d cnt_dir", idx), int'(cnt_dir), int'(r[1]));
    if (r[4] || r[3] || r[2]) begin
      ticks(PW - 1);
      check_outs("R5", r[4], r[3], r[2], 1'b0);
      ticks(1);
      check_outs("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    end else if (r[0]) begin
      ticks(1);
      check_outs("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    end
    ticks(4);
  endtask

  initial begin
    ticks(3);
    check_outs("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    check(cnt_dir == 1'b1, "R1", "cnt_dir in reset", int'(cnt_dir), 1);
    rst_n = 1'b1;
    ticks(2);
    check_outs("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    check(cnt_dir == 1'b1, "R1", "cnt_dir after reset", int'(cnt_dir), 1);

    for (int i = 0; i < NROWS; i++) run_row(ROWS[i], i);

    // R5: pulse length 1 and 0 (state 00, x4 split)
    res_mode = 2'b10; combined = 1'b0; pulse_cycles = 1;
    enc_a = 1'b1;                          // 00->10 forward
    ticks(V + 3); check_outs("R5", 1'b1, 1'b0, 1'b0, 1'b0);
    ticks(1);     check_outs("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(4);
    pulse_cycles = 0;
    enc_a = 1'b0;                          // 10->00 backward
    ticks(V + 3); check_outs("R5", 1'b0, 1'b1, 1'b0, 1'b0);
    ticks(1);     check_outs("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(4);
    pulse_cycles = PW;

    // R7: excursion one sample short of the validation length
    clear_counts();
    enc_a = 1'b1; ticks(V - 1); enc_a = 1'b0;
    ticks(20);
    check(up_falls + dn_falls == 0, "R7", "pulses after short glitch", up_falls + dn_falls, 0);
    // R7: excursion of exactly the validation length is accepted
    clear_counts();
    enc_a = 1'b1; ticks(V); enc_a = 1'b0;
    ticks(30);
    check(up_falls == 1, "R7", "up pulses after exact-length excursion", up_falls, 1);
    check(dn_falls == 1, "R7", "dn pulses after exact-length excursion", dn_falls, 1);
    // R7: val_cycles = 0 acts as 1
    val_cycles = 0;
    enc_b = 1'b1;                          // 00->01 backward
    ticks(3); check_outs("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(1); check_outs("R7", 1'b0, 1'b1, 1'b0, 1'b0);
    ticks(PW + 4);
    enc_b = 1'b0;                          // 01->00 forward
    ticks(PW + 8);
    val_cycles = V;

    // R8: dither during a pulse is ignored
    pulse_cycles = 10;
    clear_counts();
    enc_a = 1'b1;                          // 00->10 forward
    ticks(V + 3);
    check_outs("R8", 1'b1, 1'b0, 1'b0, 1'b0);
    enc_b = 1'b1; ticks(2); enc_b = 1'b0;
    ticks(40);
    check(up_falls == 1, "R8", "up pulses with dither", up_falls, 1);
    check(dn_falls == 0 && err_hits == 0, "R8", "dn pulses/errors with dither",
          dn_falls + err_hits, 0);
    // R8: a change held through the pulse is counted afterwards
    clear_counts();
    enc_a = 1'b0;                          // 10->00 backward
    ticks(V + 4);
    enc_b = 1'b1;                          // 00->01 backward, arrives mid-pulse
    ticks(5);
    check(dn_falls == 1, "R8", "dn pulses while first pulse active", dn_falls, 1);
    ticks(40);
    check(dn_falls == 2, "R8", "dn pulses after held change", dn_falls, 2);
    check(up_falls == 0, "R8", "up pulses after held change", up_falls, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule